// File: doc/BRIEF.md
# Shadowed-Compare Pulse-Width Generator

This block drives one pulse-width-modulated output from a free-running 32-bit time-base counter. Software sets it up through a small synchronous register bus. Two "live" registers hold the period limit and the compare (duty) value in use now. A second pair of "staged" registers accepts new values while the waveform is running. A staged value moves into its live register only when the counter wraps, so the cycle in progress always completes with the settings it started with.

A 16-bit control word carries four settings:
- a run bit that starts and freezes the counter;
- an output-enable bit that, when clear, forces the output low;
- a polarity bit that selects whether the compare value sets the high time or the low time;
- a two-bit restart-source field. Any value other than 2'b11 lets an external restart pulse reset the counter to zero. The value 2'b11 blocks that pulse.

The usual flow is as follows. Write the live period and compare registers while the block is stopped. Then set the run and output-enable bits. While the block runs, change the waveform only through the staged registers.

Top module: `apwm_shadow`

## Requirements
- R1: After synchronous reset, every register reads back as zero, `pwm_out` is low and `period_end` is low.
- R2: Register byte offsets are as follows. The live period is at 0x08, the live compare at 0x0C, the staged period at 0x10 and the staged compare at 0x14. These four are written at word-aligned addresses, with `bus_be[i]` enabling byte i. The control word sits in byte lanes 3:2 of offset 0x28/0x2A and reads back as {control, 16'h0}. Reads return data one cycle after the address is presented. A write to a live register takes effect on the next clock.
- R3: Control bit 4 (run) clear freezes the counter. No `period_end` pulse is then produced and `pwm_out` stays constant.
- R4: With run set and live period P ≥ 1, the counter steps 0,1,…,P and then returns to 0. `period_end` is a one-cycle pulse in the first cycle after each wrap, so a cycle lasts P+1 clocks.
- R5: With control bit 10 (polarity) clear and compare D < P, `pwm_out` is high for exactly D clocks out of every P+1.
- R6: A compare of 0 gives a constant low output. A compare ≥ P gives a constant high output (polarity clear).
- R7: With control bit 10 set, the high time becomes the low time. Compare D < P gives P+1−D high clocks per cycle.
- R8: Control bit 9 (output enable) clear holds `pwm_out` low, while the counter and `period_end` keep running.
- R9: Writes to the staged registers leave the cycle in progress and the live register contents untouched. They are copied into the live registers at the next wrap, and only if they were written since the last copy.
- R10: While control bits 7:6 are not 2'b11 and run is set, a `sync_in` pulse restarts the counter at 0 without a `period_end` pulse. While bits 7:6 equal 2'b11, `sync_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte address |
| bus_we | input | 1 | Write enable (one-cycle write) |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the address |
| sync_in | input | 1 | External counter restart pulse |
| pwm_out | output | 1 | Registered waveform output |
| period_end | output | 1 | One-cycle pulse after each counter wrap |

## Verification
A faulty counter or live period shows up at `period_end` as a pulse spacing other than P+1. This is visible within one cycle of the waveform. A faulty compare or polarity path changes the number of high clocks in any window that spans whole cycles. A staged value copied too early or never copied moves the next `period_end` edge within two cycles, and the live register read-back exposes it one clock after the read.

// File: rtl/apwm_pkg.sv
package apwm_pkg;
  // Word indices (byte offset >> 2) of the register file
  localparam int unsigned IDX_LIVE_PER  = 2;   // 0x08
  localparam int unsigned IDX_LIVE_CMP  = 3;   // 0x0C
  localparam int unsigned IDX_STAGE_PER = 4;   // 0x10
  localparam int unsigned IDX_STAGE_CMP = 5;   // 0x14
  localparam int unsigned IDX_CTRL      = 10;  // 0x28, control in lanes 3:2 (0x2A)
  // Control-word bit positions
  localparam int unsigned BIT_RUN  = 4;
  localparam int unsigned BIT_SYNC = 6;        // two bits: 7:6
  localparam int unsigned BIT_OEN  = 9;
  localparam int unsigned BIT_POL  = 10;
  localparam logic [1:0]  SYNC_BLOCKED = 2'b11;
endpackage

// File: rtl/apwm_regs.sv
module apwm_regs
  import apwm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                wrap,
  output logic [DATA_W-1:0]   live_per,
  output logic [DATA_W-1:0]   live_cmp,
  output logic                run,
  output logic                oen,
  output logic                pol,
  output logic [1:0]          sync_sel
);
  localparam int unsigned BE_W   = DATA_W / 8;
  localparam int unsigned IDX_W  = ADDR_W - 2;
  localparam int unsigned CTL_LO = DATA_W - CTRL_W;
  localparam int unsigned NCH    = 2;  // period, compare

  function automatic logic [DATA_W-1:0] merge_be(input logic [DATA_W-1:0] old_v,
                                                  input logic [DATA_W-1:0] new_v,
                                                  input logic [BE_W-1:0]   be);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < BE_W; i++)
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    return r;
  endfunction

  logic [IDX_W-1:0] idx;
  logic             aligned, is_ctrl, hit;
  assign idx     = bus_addr[ADDR_W-1:2];
  assign is_ctrl = (idx == IDX_W'(IDX_CTRL));
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign hit     = bus_we && (aligned || is_ctrl);

  logic [NCH-1:0][DATA_W-1:0] live_all, stage_all;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DATA_W-1:0] live_q, stage_q;
    logic              pend_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        live_q  <= '0;
        stage_q <= '0;
        pend_q  <= 1'b0;
      end else begin
        if (wrap && pend_q) begin
          live_q <= stage_q;
          pend_q <= 1'b0;
        end
        if (hit && idx == IDX_W'(IDX_LIVE_PER + ch))
          live_q <= merge_be(live_q, bus_wdata, bus_be);
        if (hit && idx == IDX_W'(IDX_STAGE_PER + ch)) begin
          stage_q <= merge_be(stage_q, bus_wdata, bus_be);
          pend_q  <= 1'b1;
        end
      end
    end
    assign live_all[ch]  = live_q;
    assign stage_all[ch] = stage_q;
  end

  logic [CTRL_W-1:0] ctrl_q;
  logic [DATA_W-1:0] ctrl_merged;
  assign ctrl_merged = merge_be({ctrl_q, CTL_LO'(0)}, bus_wdata, bus_be);

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (hit && is_ctrl) ctrl_q <= ctrl_merged[DATA_W-1:CTL_LO];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      unique case (idx)
        IDX_W'(IDX_LIVE_PER):  bus_rdata <= live_all[0];
        IDX_W'(IDX_LIVE_CMP):  bus_rdata <= live_all[1];
        IDX_W'(IDX_STAGE_PER): bus_rdata <= stage_all[0];
        IDX_W'(IDX_STAGE_CMP): bus_rdata <= stage_all[1];
        IDX_W'(IDX_CTRL):      bus_rdata <= {ctrl_q, CTL_LO'(0)};
        default:               bus_rdata <= '0;
      endcase
    end
  end

  assign live_per = live_all[0];
  assign live_cmp = live_all[1];
  assign run      = ctrl_q[BIT_RUN];
  assign oen      = ctrl_q[BIT_OEN];
  assign pol      = ctrl_q[BIT_POL];
  assign sync_sel = ctrl_q[BIT_SYNC +: 2];
endmodule

// File: rtl/apwm_timebase.sv
module apwm_timebase
  import apwm_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [1:0]       sync_sel,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] limit,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             period_end
);
  logic restart;
  assign wrap    = run && (cnt >= limit);
  assign restart = run && sync_in && (sync_sel != SYNC_BLOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      period_end <= 1'b0;
    end else begin
      period_end <= wrap;
      if (wrap || restart) cnt <= '0;
      else if (run)        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/apwm_wave.sv
module apwm_wave #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oen,
  input  logic             pol,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [CNT_W-1:0] limit,
  output logic             pwm_out
);
  logic active;
  assign active = (cmp != '0) && ((cnt < cmp) || (cmp >= limit));

  always_ff @(posedge clk) begin
    if (rst) pwm_out <= 1'b0;
    else     pwm_out <= oen && (active ^ pol);
  end
endmodule

// File: rtl/apwm_shadow.sv
module apwm_shadow #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned CTRL_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W/8-1:0] bus_be,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic                sync_in,
  output logic                pwm_out,
  output logic                period_end
);
  logic [DATA_W-1:0] live_per, live_cmp, cnt;
  logic              run, oen, pol, wrap;
  logic [1:0]        sync_sel;

  apwm_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_regs (
    .clk, .rst, .bus_addr, .bus_we, .bus_be, .bus_wdata, .bus_rdata,
    .wrap, .live_per, .live_cmp, .run, .oen, .pol, .sync_sel
  );

  apwm_timebase #(.CNT_W(DATA_W)) u_tb (
    .clk, .rst, .run, .sync_sel, .sync_in, .limit(live_per),
    .cnt, .wrap, .period_end
  );

  apwm_wave #(.CNT_W(DATA_W)) u_wave (
    .clk, .rst, .oen, .pol, .cnt, .cmp(live_cmp), .limit(live_per), .pwm_out
  );
endmodule

// File: rtl/apwm_shadow_chk.sv
module apwm_shadow_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              oen,
  input logic              wrap,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] live_per,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              pwm_out,
  input logic              period_end
);
  // R1
  reset_low_chk: assert property (@(posedge clk) rst |=> (!pwm_out && !period_end));

  // R3
  frozen_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (period_end && live_per != '0) |=> !period_end);

  // R8
  oen_low_chk: assert property (@(posedge clk) disable iff (rst)
    !oen |=> !pwm_out);

  // R9
  live_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wrap && !(bus_we && bus_addr == ADDR_W'(8))) |=> $stable(live_per));
endmodule

bind apwm_shadow apwm_shadow_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk, .rst, .run, .oen, .wrap, .cnt, .live_per,
  .bus_we, .bus_addr, .pwm_out, .period_end
);

// File: tb/test_apwm_shadow.sv
module test_apwm_shadow;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sync_in = 1'b0;
  logic        pwm_out, period_end;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  apwm_shadow i_apwm_shadow (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    wr(6'h2A, {v, 16'h0}, 4'b1100);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
  endtask

  task automatic wait_pe(output int t);
    do @(negedge clk); while (!period_end);
    t = cyc;
  endtask

  task automatic measure(input int n, input int exp_hi, input int exp_pe, input string tag);
    int hi = 0, pe = 0, dbl = 0;
    bit prev = 0;
    repeat (25) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += pwm_out;
      pe += period_end;
      if (prev && period_end) dbl++;
      prev = period_end;
    end
    check({tag, " high clocks"}, hi, exp_hi);
    check({tag, " period_end pulses"}, pe, exp_pe);
    check({tag, " back-to-back pulses R4"}, dbl, 0);
  endtask

  task automatic t_reset;  // R1
    check("R1 pwm_out after reset", pwm_out, 0);
    check("R1 period_end after reset", period_end, 0);
    rd(6'h08, 0, "R1 live period");
    rd(6'h0C, 0, "R1 live compare");
    rd(6'h10, 0, "R1 staged period");
    rd(6'h14, 0, "R1 staged compare");
    rd(6'h2A, 0, "R1 control");
  endtask

  task automatic t_regs;  // R2
    wr(6'h08, 9, 4'hF);
    wr(6'h0C, 3, 4'hF);
    rd(6'h08, 9, "R2 live period readback");
    wr(6'h0C, 32'hFFFF_FF05, 4'b0001);
    rd(6'h0C, 5, "R2 byte-lane write");
    wr(6'h0C, 3, 4'hF);
    wr_ctrl(16'h0210);
    rd(6'h28, 32'h0210_0000, "R2 control lanes");
  endtask

  task automatic t_run;  // R4 R5
    measure(50, 15, 5, "R4 R5 P=9 D=3");
  endtask

  task automatic t_duty_edges;  // R6
    wr(6'h0C, 0, 4'hF);
    measure(50, 0, 5, "R6 D=0");
    wr(6'h0C, 9, 4'hF);
    measure(50, 50, 5, "R6 D=P");
    wr(6'h0C, 14, 4'hF);
    measure(50, 50, 5, "R6 D>P");
    wr(6'h0C, 3, 4'hF);
  endtask

  task automatic t_pol;  // R7
    wr_ctrl(16'h0610);
    measure(50, 35, 5, "R7 inverted D=3");
  endtask

  task automatic t_oen;  // R8
    wr_ctrl(16'h0010);
    measure(50, 0, 5, "R8 output disabled");
  endtask

  task automatic t_stop;  // R3
    int hi = 0, pe = 0;
    wr_ctrl(16'h0200);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      hi += pwm_out; pe += period_end;
    end
    check("R3 period_end while frozen", pe, 0);
    check("R3 output constant while frozen", (hi == 0 || hi == 40), 1);
  endtask

  task automatic t_shadow;  // R9
    int t0, t1, t2;
    wr_ctrl(16'h0210);
    repeat (25) @(negedge clk);
    wait_pe(t0);
    wr(6'h10, 19, 4'hF);
    wr(6'h14, 7, 4'hF);
    rd(6'h08, 9, "R9 live period before boundary");
    wait_pe(t1);
    check("R9 current cycle length kept", t1 - t0, 10);
    wait_pe(t2);
    check("R9 new cycle length", t2 - t1, 20);
    rd(6'h08, 19, "R9 live period after boundary");
    rd(6'h0C, 7, "R9 live compare after boundary");
    measure(60, 21, 3, "R9 staged P=19 D=7");
  endtask

  task automatic t_sync;  // R10
    int t0, t1;
    wr(6'h10, 9, 4'hF);
    wr(6'h14, 3, 4'hF);
    repeat (45) @(negedge clk);
    wait_pe(t0);
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    wait_pe(t1);
    check("R10 restart by sync_in", t1 - t0, 15);
    wr_ctrl(16'h02D0);
    repeat (5) @(negedge clk);
    wait_pe(t0);
    repeat (4) @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    wait_pe(t1);
    check("R10 sync_in blocked", t1 - t0, 10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_run();
    t_duty_edges();
    t_pol();
    t_oen();
    t_stop();
    t_shadow();
    t_sync();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule